// File: doc/BRIEF.md
# Agree-Style Conditional Branch Direction Predictor

This block gives an instruction fetch stage a taken/not-taken guess for conditional branches. It does not learn directions directly. A small table holds one bias bit per entry. The bias bit is written with a branch's first seen outcome. A second, larger table holds 2-bit saturating counters, and each counter predicts whether the branch will follow its bias bit or go against it. Two branches that alias onto the same counter but lean the same way relative to their own biases then reinforce each other instead of fighting.

Each cycle, fetch presents the low word-address bits of the fetch address. In the same cycle it receives a predicted direction and the global history value that selected the counter. That history value travels with the branch down the pipeline. When the branch resolves, it is handed back on the resolve port together with the address bits and the actual outcome. The resolve updates the bias entry, the counter and the global history at the next clock edge. A flush input returns the whole predictor to its reset state in one cycle, for example on an address-space switch. No tags are kept, so unrelated branches can share entries.

Top module: `agree_bp`

## Requirements
- R1: After reset, `pred_hist_idx` is 0 and `pred_taken` is 0 for every `fetch_pc_lo`. The bias entries are unallocated and every counter is at weakly-agree, value 2.
- R2: `pred_hist_idx` shows the global history register. On each accepted resolve, the history shifts left by one and `res_taken` enters at bit 0. Without a resolve or flush it holds.
- R3: The bias entry is selected by `pc_lo XOR history[BIAS_IDX_W-1:0]`. The prediction side uses `fetch_pc_lo` and the current history. The resolve side uses `res_pc_lo` and `res_hist_idx`. Branches with equal index share an entry, because no tags are kept.
- R4: The counter is selected by the history value. A counter value of 2 or 3 means agree. `pred_taken` equals the bias when the counter agrees and the inverted bias when it disagrees. An unallocated bias entry reads as 0 (not-taken).
- R5: A resolve that reaches an unallocated bias entry allocates it and stores `res_taken` as its bias. Later resolves to an allocated entry never change its bias.
- R6: On resolve, the counter at `res_hist_idx` moves up by 1 (saturating at 3) when `res_taken` equals the entry's bias, and down by 1 (saturating at 0) otherwise. On allocation, the bias compared is the new outcome itself.
- R7: A counter saturated at 3 needs two consecutive disagreeing resolves before its prediction flips.
- R8: `flush` clears the history and all bias allocations and sets every counter to 2, all in one cycle. It takes priority over a resolve in the same cycle.
- R9: The prediction is combinational from `fetch_pc_lo` and the stored state. A resolve becomes visible only after the next rising clock edge.
- R10: A resolve updates the counter named by `res_hist_idx`, not the one named by the current history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all predictor state |
| fetch_pc_lo | input | BIAS_IDX_W | Low word-address bits of the fetch address |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist_idx | output | HIST_W | History value used as counter index; to be returned on resolve |
| res_valid | input | 1 | A branch outcome is presented this cycle |
| res_pc_lo | input | BIAS_IDX_W | Low word-address bits of the resolving branch |
| res_hist_idx | input | HIST_W | `pred_hist_idx` captured when the branch was predicted |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong history value shows at once on `pred_hist_idx` in the cycle after a resolve. Wrong bias or counter contents stay hidden until fetch again selects that exact entry. The history must first be steered back to the entry's index, so the bench drives runs of not-taken outcomes to bring the history back to zero before reading a trained entry. A bias that is overwritten when it should stay fixed shows only as an inverted `pred_taken` after the counter moves the other way. A counter update at the wrong index shows as a prediction at the correct index that is still unchanged.

// File: rtl/agree_bp_pkg.sv
`timescale 1ns/1ps
package agree_bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX         = 2'd3;
  localparam ctr_t CTR_MIN         = 2'd0;
  localparam ctr_t CTR_WEAK_AGREE  = 2'd2;

  // saturating step toward agree (up) or disagree (down)
  function automatic ctr_t ctr_step(input ctr_t c, input logic toward_agree);
    if (toward_agree) return (c == CTR_MAX) ? CTR_MAX : ctr_t'(c + 2'd1);
    else              return (c == CTR_MIN) ? CTR_MIN : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_agrees(input ctr_t c);
    return c[1];
  endfunction

  // agree -> follow bias, disagree -> oppose bias
  function automatic logic final_dir(input logic bias, input logic agree);
    return bias ^ ~agree;
  endfunction
endpackage

// File: rtl/agree_bp_history.sv
`timescale 1ns/1ps
module agree_bp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (flush)    hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

  assert_hist_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> hist_q == '0);
  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !flush) |=> (hist_q[0] == $past(shift_bit)) &&
                             (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
  assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !flush) |=> $stable(hist_q));
endmodule

// File: rtl/agree_bp_bias_table.sv
`timescale 1ns/1ps
module agree_bp_bias_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bias,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_outcome,
  output logic             wr_bias,
  output logic             alloc_evt
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] bias_q;

  // unallocated entries read as bias 0
  assign rd_bias   = valid_q[rd_idx] & bias_q[rd_idx];
  assign alloc_evt = wr_en & ~valid_q[wr_idx];
  assign wr_bias   = valid_q[wr_idx] ? bias_q[wr_idx] : wr_outcome;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      bias_q  <= '0;
    end else if (flush) begin
      valid_q <= '0;
      bias_q  <= '0;
    end else if (alloc_evt) begin
      valid_q[wr_idx] <= 1'b1;
      bias_q[wr_idx]  <= wr_outcome;
    end
  end

  // tracking of the last accepted write, for the checks below
  logic             seen_q, was_valid_q, old_bias_q, outcome_q;
  logic [IDX_W-1:0] idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0; was_valid_q <= 1'b0; old_bias_q <= 1'b0;
      outcome_q <= 1'b0; idx_q <= '0;
    end else begin
      seen_q      <= wr_en & ~flush;
      was_valid_q <= valid_q[wr_idx];
      old_bias_q  <= bias_q[wr_idx];
      outcome_q   <= wr_outcome;
      idx_q       <= wr_idx;
    end
  end

  assert_bias_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && was_valid_q) |-> (valid_q[idx_q] && bias_q[idx_q] == old_bias_q));
  assert_bias_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !was_valid_q) |-> (valid_q[idx_q] && bias_q[idx_q] == outcome_q));
  assert_bias_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);
endmodule

// File: rtl/agree_bp_pattern_table.sv
`timescale 1ns/1ps
module agree_bp_pattern_table
  import agree_bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_agree,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_agree
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];

  assign rd_agree = ctr_agrees(ctr_q[rd_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_AGREE;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_AGREE;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_agree);
    end
  end

  // tracking of the last accepted update, for the checks below
  logic             seen_q, agree_q;
  ctr_t             old_q;
  logic [IDX_W-1:0] idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0; agree_q <= 1'b0; old_q <= CTR_MIN; idx_q <= '0;
    end else begin
      seen_q  <= upd_en & ~flush;
      agree_q <= upd_agree;
      old_q   <= ctr_q[upd_idx];
      idx_q   <= upd_idx;
    end
  end

  assert_ctr_sat_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && agree_q && old_q == 2'd3) |-> ctr_q[idx_q] == 2'd3);
  assert_ctr_sat_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !agree_q && old_q == 2'd0) |-> ctr_q[idx_q] == 2'd0);
  assert_ctr_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && agree_q && old_q != 2'd3) |-> ctr_q[idx_q] == old_q + 2'd1);
  assert_ctr_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !agree_q && old_q != 2'd0) |-> ctr_q[idx_q] == old_q - 2'd1);
  assert_ctr_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ctr_q[0] == 2'd2);
endmodule

// File: rtl/agree_bp.sv
`timescale 1ns/1ps
module agree_bp
  import agree_bp_pkg::*;
#(
  parameter int HIST_W     = 8,
  parameter int BIAS_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [BIAS_IDX_W-1:0] fetch_pc_lo,
  output logic                  pred_taken,
  output logic [HIST_W-1:0]     pred_hist_idx,
  input  logic                  res_valid,
  input  logic [BIAS_IDX_W-1:0] res_pc_lo,
  input  logic [HIST_W-1:0]     res_hist_idx,
  input  logic                  res_taken
);
  function automatic logic [BIAS_IDX_W-1:0] bias_index(
    input logic [BIAS_IDX_W-1:0] pc_lo, input logic [HIST_W-1:0] hist);
    return pc_lo ^ hist[BIAS_IDX_W-1:0];
  endfunction

  logic [HIST_W-1:0]     hist_q;
  logic [BIAS_IDX_W-1:0] bias_rd_idx, bias_wr_idx;
  logic                  rd_bias, rd_agree;
  logic                  upd_bias, upd_agree, alloc_evt;
  logic                  upd_fire;

  assign upd_fire    = res_valid & ~flush;
  assign bias_rd_idx = bias_index(fetch_pc_lo, hist_q);
  assign bias_wr_idx = bias_index(res_pc_lo, res_hist_idx);
  assign upd_agree   = (res_taken == upd_bias);

  agree_bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .shift_en(upd_fire), .shift_bit(res_taken), .hist_q(hist_q));

  agree_bp_bias_table #(.IDX_W(BIAS_IDX_W)) u_bias (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(bias_rd_idx), .rd_bias(rd_bias),
    .wr_en(upd_fire), .wr_idx(bias_wr_idx), .wr_outcome(res_taken),
    .wr_bias(upd_bias), .alloc_evt(alloc_evt));

  agree_bp_pattern_table #(.IDX_W(HIST_W)) u_pht (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(hist_q), .rd_agree(rd_agree),
    .upd_en(upd_fire), .upd_idx(res_hist_idx), .upd_agree(upd_agree));

  assign pred_hist_idx = hist_q;
  assign pred_taken    = final_dir(rd_bias, rd_agree);

  // on allocation the outcome defines the bias, so the counter must move toward agree (R5, R6)
  assert_alloc_agrees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |-> upd_agree);
  assert_flush_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pred_hist_idx == '0) && !pred_taken);
endmodule

// File: tb/agree_bp_tb.sv
`timescale 1ns/1ps
module agree_bp_tb;
  localparam int HW = 8;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [BW-1:0] fetch_pc_lo = '0;
  logic          pred_taken;
  logic [HW-1:0] pred_hist_idx;
  logic          res_valid = 1'b0;
  logic [BW-1:0] res_pc_lo = '0;
  logic [HW-1:0] res_hist_idx = '0;
  logic          res_taken = 1'b0;

  always #2.5 clk = ~clk;

  agree_bp #(.HIST_W(HW), .BIAS_IDX_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_pc_lo(fetch_pc_lo),
    .pred_taken(pred_taken), .pred_hist_idx(pred_hist_idx),
    .res_valid(res_valid), .res_pc_lo(res_pc_lo),
    .res_hist_idx(res_hist_idx), .res_taken(res_taken));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // independent reference state
  int ref_hist;
  int ref_ctr [1 << HW];
  bit ref_bias [1 << BW];
  bit ref_val [1 << BW];

  function automatic int m_bidx(int pc, int h);
    return (pc % (1 << BW)) ^ (h % (1 << BW));
  endfunction

  function automatic bit m_pred(int pc);
    int  b = m_bidx(pc, ref_hist);
    bit  bias = ref_val[b] ? ref_bias[b] : 1'b0;
    if (ref_ctr[ref_hist] >= 2) return bias;
    return !bias;
  endfunction

  task automatic m_flush();
    ref_hist = 0;
    foreach (ref_ctr[i]) ref_ctr[i] = 2;
    foreach (ref_val[i]) begin ref_val[i] = 0; ref_bias[i] = 0; end
  endtask

  task automatic m_update(int pc, int tag, bit t);
    int b = m_bidx(pc, tag);
    if (!ref_val[b]) begin ref_val[b] = 1; ref_bias[b] = t; end
    if (t == ref_bias[b]) begin if (ref_ctr[tag] < 3) ref_ctr[tag]++; end
    else                  begin if (ref_ctr[tag] > 0) ref_ctr[tag]--; end
    ref_hist = ((ref_hist * 2) + int'(t)) % (1 << HW);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; checks happen before the rising edge
  task automatic drive(bit fl, bit rv, int pc, int tag, bit t, int fpc);
    @(negedge clk);
    flush = fl; res_valid = rv; res_pc_lo = BW'(pc);
    res_hist_idx = HW'(tag); res_taken = t; fetch_pc_lo = BW'(fpc);
    #1;
  endtask

  task automatic tick(bit fl, bit rv, int pc, int tag, bit t);
    @(posedge clk);
    if (fl) m_flush();
    else if (rv) m_update(pc, tag, t);
    #1;
    flush = 1'b0; res_valid = 1'b0;
  endtask

  task automatic resolve(int pc, int tag, bit t);
    drive(1'b0, 1'b1, pc, tag, t, pc);
    tick(1'b0, 1'b1, pc, tag, t);
  endtask

  task automatic look(int fpc);
    drive(1'b0, 1'b0, 0, 0, 1'b0, fpc);
  endtask

  task automatic zero_history();
    for (int k = 0; k < HW; k++) resolve(6'h3F, 8'hC3, 1'b0);
  endtask

  // vectors: {pc_lo[5:0], taken}
  localparam logic [6:0] VECS [16] = '{
    {6'h04, 1'b1}, {6'h04, 1'b1}, {6'h09, 1'b0}, {6'h04, 1'b1},
    {6'h11, 1'b1}, {6'h09, 1'b0}, {6'h04, 1'b0}, {6'h11, 1'b1},
    {6'h22, 1'b0}, {6'h04, 1'b1}, {6'h09, 1'b1}, {6'h11, 1'b0},
    {6'h22, 1'b0}, {6'h04, 1'b1}, {6'h09, 1'b0}, {6'h11, 1'b1}
  };

  initial begin
    m_flush();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    for (int p = 0; p < 3; p++) begin
      look(p * 21);
      chk("R1", "reset pred_taken", int'(pred_taken), 0);
    end
    chk("R1", "reset pred_hist_idx", int'(pred_hist_idx), 0);

    // vector table: prediction and resolve in the same cycle (R9: old state seen)
    for (int v = 0; v < 16; v++) begin
      int pc = int'(VECS[v][6:1]);
      bit t  = VECS[v][0];
      int tag = ref_hist;
      drive(1'b0, 1'b1, pc, tag, t, pc);
      chk("R4", "vector pred_taken", int'(pred_taken), int'(m_pred(pc)));
      chk("R2", "vector pred_hist_idx", int'(pred_hist_idx), ref_hist);
      tick(1'b0, 1'b1, pc, tag, t);
    end

    // R7: saturate counter 0 for entry 0x0A, then two disagreements
    drive(1'b1, 1'b0, 0, 0, 1'b0, 0); tick(1'b1, 1'b0, 0, 0, 1'b0);
    for (int k = 0; k < 3; k++) resolve(6'h0A, 0, 1'b1);
    zero_history();
    look(6'h0A);
    chk("R2", "history back to zero", int'(pred_hist_idx), 0);
    chk("R7", "saturated agree predicts taken", int'(pred_taken), 1);
    resolve(6'h0A, 0, 1'b0);
    look(6'h0A);
    chk("R7", "one disagreement keeps taken", int'(pred_taken), 1);
    resolve(6'h0A, 0, 1'b0);
    look(6'h0A);
    chk("R7", "second disagreement flips", int'(pred_taken), 0);

    // R5: bias stays 1 though outcomes go not-taken; one taken then leaves counter at 1
    resolve(6'h0A, 0, 1'b0);
    resolve(6'h0A, 0, 1'b1);
    zero_history();
    look(6'h0A);
    chk("R5", "bias kept, counter disagrees", int'(pred_taken), 0);
    chk("R5", "bias kept, model", int'(pred_taken), int'(m_pred(6'h0A)));

    // R10: update uses returned index 0x80, counter 0 untouched
    resolve(6'h0A, 8'h80, 1'b1);
    zero_history();
    look(6'h0A);
    chk("R10", "counter at current history untouched", int'(pred_taken), 0);

    // R8: flush wins over simultaneous resolve
    drive(1'b1, 1'b1, 6'h0A, 0, 1'b1, 6'h0A);
    tick(1'b1, 1'b1, 6'h0A, 0, 1'b1);
    look(6'h0A);
    chk("R8", "flush clears history", int'(pred_hist_idx), 0);
    chk("R8", "flush clears bias", int'(pred_taken), 0);

    // R3 / R6: allocate bias 0 at entry 0, bias 1 at entry 1; history 1 remaps fetch of pc 0
    resolve(6'h00, 0, 1'b0);
    look(6'h00);
    chk("R6", "allocated bias 0 agreeing", int'(pred_taken), 0);
    resolve(6'h01, 0, 1'b1);
    look(6'h00);
    chk("R3", "history xor selects entry 1", int'(pred_taken), 1);
    chk("R3", "history xor model", int'(pred_taken), int'(m_pred(6'h00)));

    // R9: no update without an edge; combinational change with fetch address
    look(6'h21);
    chk("R9", "other entry unallocated", int'(pred_taken), int'(m_pred(6'h21)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule